// File: doc/BRIEF.md
# Instruction Fetch Request Master

This block sits on the requesting side of an instruction-fetch bus port. A core-side agent hands it one fetch command at a time (an address and a one-bit storage attribute) through a valid/ready pair. The block captures the command in a one-entry holding register, tags it with a 2-bit priority taken from a software-writable configuration field, and presents it on the bus as a request with address, priority and attribute qualifiers until the bus slave acknowledges the address. While the request is up, the core may raise an abort. The block passes that abort to the slave and withdraws the request, even when the slave acknowledges in the same cycle.

Control is a four-state machine. `ST_IDLE` has nothing pending. `ST_REQ` drives the request. `ST_HOLD` is the single cycle after an acknowledge, during which the qualifiers are held for the slave. `ST_GAP` is the single cycle after an abort, during which the request is held low. The transitions are as follows. Issue (idle, hold or gap to `ST_REQ` on an accepted command). Wait (`ST_REQ` to itself with neither acknowledge nor abort). Ack (`ST_REQ` to `ST_HOLD` on acknowledge without abort). Abort (`ST_REQ` to `ST_GAP` on abort, whether or not acknowledge is present). Retire (hold or gap to `ST_IDLE` when no command is offered).

A command may be accepted during the hold cycle, so a new address can go out while the slave is still busy with the previous transfer. Data return is outside this block.

Top module: `ifetch_req_master`

## Requirements
- R1: After reset, `bus_req` and `bus_abort` are 0, `cmd_ready` is 1, and the priority field holds 2'b11, so the first request after reset carries priority 2'b11.
- R2: A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both 1. `bus_req` is 1 in the following cycle, with `bus_addr` equal to the accepted `cmd_addr` and `bus_attr` equal to the accepted `cmd_attr` (1 = location carries the user-defined attribute, 0 = it does not).
- R3: `bus_prio` carries the value that the priority field held in the cycle the command was accepted. The encoding is 2'b00 lowest, 2'b01 next-to-lowest, 2'b10 next-to-highest, 2'b11 highest.
- R4: A cycle with `cfg_wr_en` = 1 loads `cfg_wr_prio` into the priority field. A write made while a request is outstanding leaves that request's `bus_prio` unchanged, and the new value applies from the next accepted command onward.
- R5: `bus_addr`, `bus_prio` and `bus_attr` stay constant from the first cycle of a request through the cycle after the acknowledge.
- R6: After an acknowledge without abort, `bus_req` is 0 in the next cycle, and `cmd_ready` is 1 in that cycle so that a new request can start in the cycle after it.
- R7: `bus_abort` follows `cmd_abort` while `bus_req` is 1 and is 0 whenever `bus_req` is 0. An abort raised with no request outstanding has no effect on any output.
- R8: After a cycle with `bus_abort` = 1 (with or without `bus_addr_ack` in that same cycle), `bus_req` is 0 in the next cycle. The next request starts no earlier than two cycles after the abort cycle.
- R9: While a request is outstanding, `cmd_ready` is 0, and an offered command is held off until it can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the priority field |
| cfg_wr_prio | input | 2 | New priority value |
| cmd_valid | input | 1 | Core offers a fetch command |
| cmd_addr | input | ADDR_W | Fetch address |
| cmd_attr | input | 1 | User-defined storage attribute of the fetch target |
| cmd_abort | input | 1 | Core asks to abort the outstanding request |
| cmd_ready | output | 1 | Block can take a command this cycle |
| bus_req | output | 1 | Fetch request to the bus slave |
| bus_addr | output | ADDR_W | Request address qualifier |
| bus_prio | output | 2 | Request priority qualifier |
| bus_attr | output | 1 | Request storage attribute qualifier |
| bus_abort | output | 1 | Abort of the current request |
| bus_addr_ack | input | 1 | Slave acknowledges the request address |

## Verification
The slave's address acknowledge and the core's abort can land in the same cycle. In that case the abort must win: the hold cycle is skipped, the request drops for exactly the gap cycle, and a command offered in the gap cycle goes out two cycles after the abort. The bench provokes this on purpose, and also by driving acknowledge and abort at random on every cycle. A behavioural model that tracks only "pending" and "held" flags judges each cycle's request, abort, ready and qualifier values. Priority writes that fall inside an outstanding request are mixed in, so that a write colliding with a live request is caught if it changes that request's priority.

// File: rtl/ifreq_pkg.sv
package ifreq_pkg;

    localparam int PRIO_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_HOLD,
        ST_GAP
    } fetch_state_e;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              attr;
    } fetch_qual_t;

endpackage

// File: rtl/ifreq_cfg.sv
module ifreq_cfg
    import ifreq_pkg::*;
#(
    parameter logic [PRIO_W-1:0] RESET_PRIO = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PRIO_W-1:0] wr_val,
    output logic [PRIO_W-1:0] prio_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= RESET_PRIO;
        end else if (wr_en) begin
            prio_q <= wr_val;
        end
    end

endmodule

// File: rtl/ifreq_fsm.sv
module ifreq_fsm
    import ifreq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_abort,
    input  logic addr_ack,
    output logic cmd_ready,
    output logic capture,
    output logic bus_req,
    output logic bus_abort
);

    fetch_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_HOLD, ST_GAP: begin
                state_d = cmd_valid ? ST_REQ : ST_IDLE;
            end
            ST_REQ: begin
                if (cmd_abort) begin
                    state_d = ST_GAP;
                end else if (addr_ack) begin
                    state_d = ST_HOLD;
                end else begin
                    state_d = ST_REQ;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready = 1'b1;
        bus_req   = 1'b0;
        bus_abort = 1'b0;
        unique case (state_q)
            ST_REQ: begin
                cmd_ready = 1'b0;
                bus_req   = 1'b1;
                bus_abort = cmd_abort;
            end
            ST_IDLE, ST_HOLD, ST_GAP: begin
                cmd_ready = 1'b1;
            end
            default: begin
                cmd_ready = 1'b0;
            end
        endcase
        capture = cmd_ready & cmd_valid;
    end

    // an abort cycle is followed by a cycle without request
    assert_gap_after_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ && cmd_abort) |=> (state_q == ST_GAP));

    // acknowledge without abort leads to the hold cycle
    assert_hold_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ && addr_ack && !cmd_abort) |=> (state_q == ST_HOLD));

endmodule

// File: rtl/ifreq_qual.sv
module ifreq_qual
    import ifreq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              attr_in,
    input  logic [PRIO_W-1:0] prio_in,
    output logic [ADDR_W-1:0] addr_q,
    output fetch_qual_t       qual_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            qual_q <= '0;
        end else if (capture) begin
            addr_q      <= addr_in;
            qual_q.prio <= prio_in;
            qual_q.attr <= attr_in;
        end
    end

endmodule

// File: rtl/ifetch_req_master.sv
module ifetch_req_master
    import ifreq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_prio,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_attr,
    input  logic              cmd_abort,
    output logic              cmd_ready,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_prio,
    output logic              bus_attr,
    output logic              bus_abort,
    input  logic              bus_addr_ack
);

    logic [PRIO_W-1:0] cfg_prio;
    logic              capture;
    fetch_qual_t       qual;

    ifreq_cfg #(.RESET_PRIO(2'b11)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .wr_val (cfg_wr_prio),
        .prio_q (cfg_prio)
    );

    ifreq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_abort (cmd_abort),
        .addr_ack  (bus_addr_ack),
        .cmd_ready (cmd_ready),
        .capture   (capture),
        .bus_req   (bus_req),
        .bus_abort (bus_abort)
    );

    ifreq_qual #(.ADDR_W(ADDR_W)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .addr_in (cmd_addr),
        .attr_in (cmd_attr),
        .prio_in (cfg_prio),
        .addr_q  (bus_addr),
        .qual_q  (qual)
    );

    assign bus_prio = qual.prio;
    assign bus_attr = qual.attr;

    assert_abort_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_abort |-> bus_req);

    assert_req_low_after_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_abort) |=> !bus_req);

    assert_req_low_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr_ack) |=> !bus_req);

    assert_qual_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_abort) |=>
            ($stable(bus_addr) && $stable(bus_prio) && $stable(bus_attr)));

    assert_no_ready_in_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cmd_ready);

endmodule

// File: tb/ifetch_req_master_test.sv
`timescale 1ns/1ps
module ifetch_req_master_test;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_wr_en, cmd_valid, cmd_attr, cmd_abort, bus_addr_ack;
    logic [1:0]    cfg_wr_prio;
    logic [AW-1:0] cmd_addr;
    logic          cmd_ready, bus_req, bus_attr, bus_abort;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_prio;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit          m_pend;
    bit          m_hold;
    bit          m_prev_abort;
    bit          m_prev_ack;
    logic [1:0]  m_cfg;
    logic [1:0]  m_prio;
    logic        m_attr;
    logic [AW-1:0] m_addr;

    always #5 clk = ~clk;

    ifetch_req_master #(.ADDR_W(AW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_prio  (cfg_wr_prio),
        .cmd_valid    (cmd_valid),
        .cmd_addr     (cmd_addr),
        .cmd_attr     (cmd_attr),
        .cmd_abort    (cmd_abort),
        .cmd_ready    (cmd_ready),
        .bus_req      (bus_req),
        .bus_addr     (bus_addr),
        .bus_prio     (bus_prio),
        .bus_attr     (bus_attr),
        .bus_abort    (bus_abort),
        .bus_addr_ack (bus_addr_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle(input logic v, input logic [AW-1:0] a, input logic at,
                         input logic ab, input logic ak,
                         input logic w, input logic [1:0] wp);
        bit acc, abort_now, ack_now;
        logic [1:0] cfg_old;
        cmd_valid = v; cmd_addr = a; cmd_attr = at; cmd_abort = ab;
        bus_addr_ack = ak; cfg_wr_en = w; cfg_wr_prio = wp;
        #1;
        chk(m_prev_abort ? "R8 req" : (m_prev_ack ? "R6 req" : "R2 req"),
            {31'd0, bus_req}, {31'd0, m_pend});
        chk("R7 abort", {31'd0, bus_abort}, {31'd0, m_pend & ab});
        chk("R9 ready", {31'd0, cmd_ready}, {31'd0, ~m_pend});
        if (m_pend || m_hold) begin
            chk("R3 prio", {30'd0, bus_prio}, {30'd0, m_prio});
            chk("R5 addr", {16'd0, bus_addr}, {16'd0, m_addr});
            chk("R5 attr", {31'd0, bus_attr}, {31'd0, m_attr});
        end
        @(posedge clk);
        acc       = v && !m_pend;
        abort_now = m_pend && ab;
        ack_now   = m_pend && ak;
        cfg_old   = m_cfg;
        if (w) m_cfg = wp;
        m_prev_abort = abort_now;
        m_prev_ack   = ack_now && !abort_now;
        m_hold       = ack_now && !abort_now;
        if (m_pend) begin
            if (abort_now || ack_now) m_pend = 1'b0;
        end else if (acc) begin
            m_pend = 1'b1;
            m_addr = a;
            m_attr = at;
            m_prio = cfg_old;
        end
        @(negedge clk);
    endtask

    initial begin
        #(20000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_wr_en = 0; cfg_wr_prio = 0; cmd_valid = 0; cmd_addr = 0;
        cmd_attr = 0; cmd_abort = 0; bus_addr_ack = 0;
        m_pend = 0; m_hold = 0; m_prev_abort = 0; m_prev_ack = 0;
        m_cfg = 2'b11; m_prio = 0; m_attr = 0; m_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 req", {31'd0, bus_req}, 32'd0);
        chk("R1 abort", {31'd0, bus_abort}, 32'd0);
        chk("R1 ready", {31'd0, cmd_ready}, 32'd1);

        // R7: abort with nothing outstanding is ignored
        cycle(0, 16'h0, 0, 1, 0, 0, 2'b00);
        chk("R7 idle abort no req", {31'd0, bus_req}, 32'd0);

        // R2/R1: first request carries reset priority
        cycle(1, 16'h0100, 1, 0, 0, 0, 2'b00);
        chk("R1 reset prio", {30'd0, bus_prio}, 32'd3);
        chk("R2 addr", {16'd0, bus_addr}, 32'h0100);
        // R9: command offered while pending is held off; R4 write during request
        cycle(1, 16'h0BAD, 0, 0, 0, 1, 2'b01);
        chk("R4 prio unchanged", {30'd0, bus_prio}, 32'd3);
        cycle(1, 16'h0BAD, 0, 0, 1, 0, 2'b00);          // ack
        // R6: hold cycle, new command accepted here
        chk("R6 req low", {31'd0, bus_req}, 32'd0);
        cycle(1, 16'h0204, 0, 0, 0, 0, 2'b00);
        chk("R4 new prio", {30'd0, bus_prio}, 32'd1);
        chk("R6 pipelined req", {31'd0, bus_req}, 32'd1);
        // R8: abort and ack in the same cycle
        cycle(0, 16'h0, 0, 1, 1, 0, 2'b00);
        chk("R8 req low after abort", {31'd0, bus_req}, 32'd0);
        cycle(1, 16'h0308, 1, 0, 0, 1, 2'b10);          // gap cycle accept
        chk("R8 reissue two cycles after", {31'd0, bus_req}, 32'd1);
        chk("R8 addr", {16'd0, bus_addr}, 32'h0308);
        // abort without ack
        cycle(0, 16'h0, 0, 0, 0, 0, 2'b00);
        cycle(0, 16'h0, 0, 1, 0, 0, 2'b00);
        chk("R8 gap", {31'd0, bus_req}, 32'd0);
        cycle(0, 16'h0, 0, 1, 0, 0, 2'b00);
        chk("R7 abort in gap ignored", {31'd0, bus_req}, 32'd0);
        cycle(1, 16'h0410, 0, 0, 0, 0, 2'b00);
        chk("R3 prio after write", {30'd0, bus_prio}, 32'd2);

        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            cycle(r[0] | r[1], r[31:16], r[2], (r[5:3] == 3'd0), r[6] & r[7],
                  (r[10:8] == 3'd0), r[12:11]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule